// File: doc/BRIEF.md
# Bit-band alias bridge

This block sits between a processor-side memory port and a downstream memory or peripheral port. Each of two primary regions, 1 MB at 0x20000000 and 1 MB at 0x40000000, has a 32 MB alias window at its base plus 0x02000000. In that window every bit of the primary region appears as its own aligned 32-bit word. A read of an alias word returns the single target bit. A write to an alias word changes only that bit, through a read-modify-write that the bridge runs in hardware under a downstream lock.

Every other address passes through unchanged as one downstream transaction. This includes ordinary word accesses inside the primary regions. Both ports use a valid/ready request carrying an address, a write enable and 32-bit write data. Each completed downstream transaction, read or write, returns exactly one `dn_rvalid_i` pulse. The bridge returns one `up_rvalid_o` pulse for each upstream request it accepts. The bridge holds one request at a time, and every downstream response arrives at least one cycle after its request is accepted.

Top module: `bitband_bridge`

## Requirements
- R1: An address is an alias hit when it lies in 0x22000000..0x23FFFFFF or in 0x42000000..0x43FFFFFF. Any other address, including 0x21FFFFFC, 0x24000000, 0x41FFFFFC and 0x44000000, is not a hit.
- R2: For a hit, the primary byte is the region base plus alias-address bits 24:5, and the bit-in-byte is alias-address bits 4:2. The downstream address is that byte address with bits 1:0 cleared. The bit index in the word is byte-address bits 1:0 times 8 plus the bit-in-byte, with little-endian bit numbering. Examples: 0x22006008 gives word 0x20000300, bit 2. 0x422181A0 gives word 0x40010C0C, bit 8.
- R3: An alias read makes exactly one downstream transaction. That transaction is a read (`dn_we_o` low) of the target word, with `dn_lock_o` low.
- R4: Read data for an alias read has bit 0 equal to the target bit and bits 31:1 zero.
- R5: An alias write makes exactly two downstream transactions to the target word: a read, then a write. The word written equals the word read, with only the target bit replaced by bit 0 of the upstream write data.
- R6: `dn_lock_o` is high from the read request of an alias write until that write's response arrives. It is low for every other transaction and whenever the bridge is idle.
- R7: `up_ready_o` stays low from the acceptance of a request until its response has been returned.
- R8: A non-hit access makes exactly one downstream transaction with the same address, write enable and write data. A non-hit read returns the downstream read data unmodified.
- R9: Once `dn_valid_o` is high, it stays high with unchanged address, write enable and write data until `dn_ready_i` is seen high.
- R10: Each accepted request yields exactly one single-cycle `up_rvalid_o` pulse. After that pulse the bridge is idle. Write responses carry zero data.
- R11: During reset `up_ready_o` is high, and `dn_valid_o`, `dn_lock_o` and `up_rvalid_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| up_valid_i | input | 1 | Upstream request valid |
| up_ready_o | output | 1 | Bridge accepts an upstream request |
| up_addr_i | input | 32 | Upstream byte address |
| up_we_i | input | 1 | Upstream write enable |
| up_wdata_i | input | 32 | Upstream write data |
| up_rvalid_o | output | 1 | Upstream response pulse |
| up_rdata_o | output | 32 | Upstream read data |
| dn_valid_o | output | 1 | Downstream request valid |
| dn_ready_i | input | 1 | Downstream accepts the request |
| dn_addr_o | output | 32 | Downstream byte address |
| dn_we_o | output | 1 | Downstream write enable |
| dn_wdata_o | output | 32 | Downstream write data |
| dn_lock_o | output | 1 | Downstream lock held across a read-modify-write |
| dn_rvalid_i | input | 1 | Downstream response pulse |
| dn_rdata_i | input | 32 | Downstream read data |

## Verification
The bench builds the bridge with its default parameters: two regions of 1 MB at 0x20000000 and 0x40000000, and an alias gap of 0x02000000. These defaults put the two worked translation examples and the exact edges of both alias windows within reach as directed cases. Random traffic draws its addresses from a small pool of primary words. Alias reads, alias writes and plain word accesses therefore keep landing on the same words, so a wrong bit index or a corrupted neighbouring bit shows up in later reads. The downstream model stalls ready at random and delays each response by one to three cycles. This exercises request holding, lock timing and upstream blocking.

// File: rtl/bb_pkg.sv
package bb_pkg;
  localparam int AW       = 32;
  localparam int DW       = 32;
  localparam int BIT_W    = $clog2(DW);
  localparam int WORD_LSB = $clog2(DW / 8);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PASS_REQ,
    ST_PASS_WAIT,
    ST_RD_REQ,
    ST_RD_WAIT,
    ST_WR_REQ,
    ST_WR_WAIT,
    ST_RESP
  } bb_state_e;

  typedef struct packed {
    logic             hit;
    logic [AW-1:0]    word_addr;
    logic [BIT_W-1:0] bit_idx;
  } bb_xlat_t;

  function automatic logic [DW-1:0] bit_insert(input logic [DW-1:0] w,
                                               input logic [BIT_W-1:0] idx,
                                               input logic v);
    logic [DW-1:0] r;
    r      = w;
    r[idx] = v;
    return r;
  endfunction
endpackage

// File: rtl/bb_decode.sv
module bb_decode
  import bb_pkg::*;
#(
  parameter int                               NUM_REGIONS = 2,
  parameter int                               REGION_LOG2 = 20,
  parameter logic [AW-1:0]                    ALIAS_GAP   = 32'h0200_0000,
  parameter logic [NUM_REGIONS-1:0][AW-1:0]   REGION_BASE = {32'h4000_0000, 32'h2000_0000}
) (
  input  logic [AW-1:0] addr_i,
  output bb_xlat_t      xlat_o
);
  localparam int BYTE_BITS_W = 3;
  localparam int SHIFT       = BYTE_BITS_W + WORD_LSB;
  localparam int ALIAS_LOG2  = REGION_LOG2 + SHIFT;

  logic [NUM_REGIONS-1:0]         hit;
  logic [NUM_REGIONS-1:0][AW-1:0] byte_addr;

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_region
    localparam logic [AW-1:0] ABASE = REGION_BASE[g] + ALIAS_GAP;
    assign hit[g]       = (addr_i[AW-1:ALIAS_LOG2] == ABASE[AW-1:ALIAS_LOG2]);
    assign byte_addr[g] = REGION_BASE[g] + AW'(addr_i[ALIAS_LOG2-1:SHIFT]);
  end

  // lowest region index wins if windows were ever made to overlap
  always_comb begin
    xlat_o = '0;
    for (int r = NUM_REGIONS - 1; r >= 0; r--) begin
      if (hit[r]) begin
        xlat_o.hit       = 1'b1;
        xlat_o.word_addr = {byte_addr[r][AW-1:WORD_LSB], {WORD_LSB{1'b0}}};
        xlat_o.bit_idx   = {byte_addr[r][WORD_LSB-1:0], addr_i[SHIFT-1:WORD_LSB]};
      end
    end
  end

  always_comb begin
    assert_one_window_R1: assert ($onehot0(hit))
      else $error("alias windows overlap");
  end
endmodule

// File: rtl/bb_ctrl.sv
module bb_ctrl
  import bb_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          up_valid_i,
  output logic          up_ready_o,
  input  logic [AW-1:0] up_addr_i,
  input  logic          up_we_i,
  input  logic [DW-1:0] up_wdata_i,
  input  bb_xlat_t      xlat_i,
  output logic          up_rvalid_o,
  output logic [DW-1:0] up_rdata_o,
  output logic          dn_valid_o,
  input  logic          dn_ready_i,
  output logic [AW-1:0] dn_addr_o,
  output logic          dn_we_o,
  output logic [DW-1:0] dn_wdata_o,
  output logic          dn_lock_o,
  input  logic          dn_rvalid_i,
  input  logic [DW-1:0] dn_rdata_i
);
  bb_state_e        state_q;
  logic [AW-1:0]    addr_q;
  logic             we_q;
  logic             alias_q;
  logic [DW-1:0]    wdata_q;
  logic [BIT_W-1:0] bit_q;
  logic [DW-1:0]    rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      we_q    <= 1'b0;
      alias_q <= 1'b0;
      wdata_q <= '0;
      bit_q   <= '0;
      rdata_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (up_valid_i) begin
          alias_q <= xlat_i.hit;
          addr_q  <= xlat_i.hit ? xlat_i.word_addr : up_addr_i;
          bit_q   <= xlat_i.bit_idx;
          we_q    <= up_we_i;
          wdata_q <= up_wdata_i;
          state_q <= xlat_i.hit ? ST_RD_REQ : ST_PASS_REQ;
        end
        ST_PASS_REQ: if (dn_ready_i) state_q <= ST_PASS_WAIT;
        ST_PASS_WAIT: if (dn_rvalid_i) begin
          rdata_q <= we_q ? '0 : dn_rdata_i;
          state_q <= ST_RESP;
        end
        ST_RD_REQ: if (dn_ready_i) state_q <= ST_RD_WAIT;
        ST_RD_WAIT: if (dn_rvalid_i) begin
          if (we_q) begin
            wdata_q <= bit_insert(dn_rdata_i, bit_q, wdata_q[0]);
            state_q <= ST_WR_REQ;
          end else begin
            rdata_q <= {{(DW-1){1'b0}}, dn_rdata_i[bit_q]};
            state_q <= ST_RESP;
          end
        end
        ST_WR_REQ: if (dn_ready_i) state_q <= ST_WR_WAIT;
        ST_WR_WAIT: if (dn_rvalid_i) begin
          rdata_q <= '0;
          state_q <= ST_RESP;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    up_ready_o  = (state_q == ST_IDLE);
    up_rvalid_o = (state_q == ST_RESP);
    up_rdata_o  = rdata_q;
    dn_valid_o  = (state_q == ST_PASS_REQ) || (state_q == ST_RD_REQ) || (state_q == ST_WR_REQ);
    dn_addr_o   = addr_q;
    dn_we_o     = ((state_q == ST_PASS_REQ) && we_q) || (state_q == ST_WR_REQ);
    dn_wdata_o  = wdata_q;
    dn_lock_o   = alias_q && we_q &&
                  ((state_q == ST_RD_REQ) || (state_q == ST_RD_WAIT) ||
                   (state_q == ST_WR_REQ) || (state_q == ST_WR_WAIT));
  end

  assert_lock_blocks_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dn_lock_o |-> !up_ready_o) else $error("upstream open during locked update");

  assert_req_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dn_valid_o && !dn_ready_i |=> dn_valid_o && $stable(dn_addr_o) && $stable(dn_we_o)
                                  && $stable(dn_wdata_o)) else $error("request dropped");

  assert_single_resp_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    up_rvalid_o |=> !up_rvalid_o && up_ready_o) else $error("response not single");

  assert_rd_zext_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    up_rvalid_o && alias_q && !we_q |-> up_rdata_o[DW-1:1] == '0) else $error("alias read not zero-extended");

  assert_lock_end_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dn_lock_o) |-> up_rvalid_o) else $error("lock released early");

  assert_alias_wr_locked_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dn_valid_o && dn_we_o && alias_q |-> dn_lock_o) else $error("alias write without lock");

  assert_alias_rd_plain_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dn_valid_o && alias_q && !we_q |-> !dn_we_o && !dn_lock_o) else $error("alias read malformed");
endmodule

// File: rtl/bitband_bridge.sv
module bitband_bridge
  import bb_pkg::*;
#(
  parameter int                             NUM_REGIONS = 2,
  parameter int                             REGION_LOG2 = 20,
  parameter logic [AW-1:0]                  ALIAS_GAP   = 32'h0200_0000,
  parameter logic [NUM_REGIONS-1:0][AW-1:0] REGION_BASE = {32'h4000_0000, 32'h2000_0000}
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          up_valid_i,
  output logic          up_ready_o,
  input  logic [31:0]   up_addr_i,
  input  logic          up_we_i,
  input  logic [31:0]   up_wdata_i,
  output logic          up_rvalid_o,
  output logic [31:0]   up_rdata_o,
  output logic          dn_valid_o,
  input  logic          dn_ready_i,
  output logic [31:0]   dn_addr_o,
  output logic          dn_we_o,
  output logic [31:0]   dn_wdata_o,
  output logic          dn_lock_o,
  input  logic          dn_rvalid_i,
  input  logic [31:0]   dn_rdata_i
);
  bb_xlat_t xlat;

  bb_decode #(
    .NUM_REGIONS(NUM_REGIONS),
    .REGION_LOG2(REGION_LOG2),
    .ALIAS_GAP  (ALIAS_GAP),
    .REGION_BASE(REGION_BASE)
  ) u_decode (
    .addr_i(up_addr_i),
    .xlat_o(xlat)
  );

  bb_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .up_valid_i (up_valid_i),
    .up_ready_o (up_ready_o),
    .up_addr_i  (up_addr_i),
    .up_we_i    (up_we_i),
    .up_wdata_i (up_wdata_i),
    .xlat_i     (xlat),
    .up_rvalid_o(up_rvalid_o),
    .up_rdata_o (up_rdata_o),
    .dn_valid_o (dn_valid_o),
    .dn_ready_i (dn_ready_i),
    .dn_addr_o  (dn_addr_o),
    .dn_we_o    (dn_we_o),
    .dn_wdata_o (dn_wdata_o),
    .dn_lock_o  (dn_lock_o),
    .dn_rvalid_i(dn_rvalid_i),
    .dn_rdata_i (dn_rdata_i)
  );
endmodule

// File: tb/sim_bitband_bridge.sv
module sim_bitband_bridge;
  logic        clk = 1'b0;
  logic        rst_ni;
  logic        up_valid, up_we;
  logic [31:0] up_addr, up_wdata;
  logic        up_ready_o, up_rvalid_o;
  logic [31:0] up_rdata_o;
  logic        dn_valid_o, dn_we_o, dn_lock_o;
  logic [31:0] dn_addr_o, dn_wdata_o;
  logic        dn_ready, dn_rvalid;
  logic [31:0] dn_rdata;

  int n_chk = 0;
  int n_bad = 0;

  logic [31:0] dmem [logic [31:0]];
  logic [31:0] refm [logic [31:0]];
  logic [31:0] txn_addr  [4];
  logic        txn_we    [4];
  logic [31:0] txn_wdata [4];
  logic        txn_lock  [4];
  int          txn_n;

  always #4 clk = ~clk;

  bitband_bridge u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .up_valid_i(up_valid), .up_ready_o(up_ready_o), .up_addr_i(up_addr),
    .up_we_i(up_we), .up_wdata_i(up_wdata), .up_rvalid_o(up_rvalid_o), .up_rdata_o(up_rdata_o),
    .dn_valid_o(dn_valid_o), .dn_ready_i(dn_ready), .dn_addr_o(dn_addr_o), .dn_we_o(dn_we_o),
    .dn_wdata_o(dn_wdata_o), .dn_lock_o(dn_lock_o), .dn_rvalid_i(dn_rvalid), .dn_rdata_i(dn_rdata)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] seed_val(input logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
  endfunction

  function automatic logic [31:0] dmem_get(input logic [31:0] a);
    return dmem.exists(a) ? dmem[a] : seed_val(a);
  endfunction

  function automatic logic [31:0] refm_get(input logic [31:0] a);
    return refm.exists(a) ? refm[a] : seed_val(a);
  endfunction

  // expected translation, taken from R1 and R2
  function automatic void dec(input logic [31:0] a, output bit hit,
                              output logic [31:0] word, output int bitn);
    logic [31:0] base, byt;
    hit = 1'b0; base = '0; word = a; bitn = 0;
    if (a[31:25] == 7'h11) begin hit = 1'b1; base = 32'h2000_0000; end
    else if (a[31:25] == 7'h21) begin hit = 1'b1; base = 32'h4000_0000; end
    if (hit) begin
      byt  = base + {12'd0, a[24:5]};
      word = {byt[31:2], 2'b00};
      bitn = int'(byt[1:0]) * 8 + int'(a[4:2]);
    end
  endfunction

  function automatic logic [31:0] alias_of(input logic [31:0] word, input int bitn);
    logic [31:0] byt, base;
    byt  = word + 32'(bitn / 8);
    base = {byt[31:28], 28'd0};
    return base + 32'h0200_0000 + ({12'd0, byt[19:0]} << 5) + 32'((bitn % 8) << 2);
  endfunction

  // downstream memory model with random stalls and latency
  initial begin
    int          cnt;
    logic [31:0] pend, hold_addr;
    bit          hold_chk;
    cnt = 0; pend = '0; hold_addr = '0; hold_chk = 0;
    dn_ready = 1'b0; dn_rvalid = 1'b0; dn_rdata = '0; txn_n = 0;
    forever begin
      @(negedge clk);
      dn_rvalid = 1'b0;
      if (hold_chk)
        chk(dn_valid_o && dn_addr_o == hold_addr, "R9", "stalled request held", dn_addr_o, hold_addr);
      if (cnt > 0) begin
        cnt--;
        if (cnt == 0) begin dn_rvalid = 1'b1; dn_rdata = pend; end
      end
      dn_ready = 1'b0;
      hold_chk = 0;
      if (dn_valid_o && cnt == 0 && !dn_rvalid) begin
        if ($urandom % 4 != 0) begin
          dn_ready = 1'b1;
          if (txn_n < 4) begin
            txn_addr[txn_n] = dn_addr_o; txn_we[txn_n] = dn_we_o;
            txn_wdata[txn_n] = dn_wdata_o; txn_lock[txn_n] = dn_lock_o;
          end
          txn_n++;
          if (dn_we_o) begin dmem[dn_addr_o] = dn_wdata_o; pend = '0; end
          else pend = dmem_get(dn_addr_o);
          cnt = 1 + int'($urandom % 3);
        end else begin
          hold_chk = 1; hold_addr = dn_addr_o;
        end
      end
    end
  end

  task automatic run_op(input logic [31:0] a, input logic we, input logic [31:0] wd,
                        output logic [31:0] rd);
    bit hit; logic [31:0] word, rw, mg; int bitn, leak;
    dec(a, hit, word, bitn);
    txn_n = 0; leak = 0;
    up_valid = 1'b1; up_addr = a; up_we = we; up_wdata = wd;
    while (!up_ready_o) @(negedge clk);
    @(negedge clk);
    up_valid = 1'b0;
    while (!up_rvalid_o) begin
      if (up_ready_o) leak++;
      @(negedge clk);
    end
    rd = up_rdata_o;
    chk(leak == 0, "R7", "ready while busy", 32'(leak), 0);
    if (!hit) begin
      chk(txn_n == 1, "R8", "pass txn count", 32'(txn_n), 1);
      chk(txn_addr[0] == a && txn_we[0] == we, "R8", "pass addr", txn_addr[0], a);
      chk(!txn_lock[0], "R6", "pass lock", 32'(txn_lock[0]), 0);
      if (we) begin
        chk(txn_wdata[0] == wd, "R8", "pass wdata", txn_wdata[0], wd);
        refm[a] = wd;
        chk(rd == 0, "R10", "write resp data", rd, 0);
      end else chk(rd == refm_get(a), "R8", "pass rdata", rd, refm_get(a));
    end else if (!we) begin
      rw = refm_get(word);
      chk(txn_n == 1 && !txn_we[0], "R3", "alias read txn", 32'(txn_n), 1);
      chk(txn_addr[0] == word, "R2", "alias read addr", txn_addr[0], word);
      chk(!txn_lock[0], "R6", "alias read lock", 32'(txn_lock[0]), 0);
      chk(rd == {31'd0, rw[bitn]}, "R4", "alias rdata", rd, {31'd0, rw[bitn]});
    end else begin
      rw = refm_get(word); mg = rw; mg[bitn] = wd[0];
      chk(txn_n == 2, "R5", "alias write txn count", 32'(txn_n), 2);
      chk(txn_addr[0] == word && !txn_we[0], "R5", "rmw read phase", txn_addr[0], word);
      chk(txn_addr[1] == word && txn_we[1], "R2", "rmw write addr", txn_addr[1], word);
      chk(txn_wdata[1] == mg, "R5", "rmw merged word", txn_wdata[1], mg);
      chk(txn_lock[0] && txn_lock[1], "R6", "rmw lock", {30'd0, txn_lock[0], txn_lock[1]}, 3);
      refm[word] = mg;
    end
    @(negedge clk);
    chk(!up_rvalid_o && up_ready_o, "R10", "single response", {30'd0, up_rvalid_o, up_ready_o}, 1);
    chk(!dn_lock_o, "R6", "lock idle", 32'(dn_lock_o), 0);
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R10 watchdog act=hung exp=complete");
    finish_run();
  end

  initial begin
    logic [31:0] rd, w, exp;
    void'($urandom(32'd1234));
    rst_ni = 1'b0; up_valid = 1'b0; up_we = 1'b0; up_addr = '0; up_wdata = '0;
    repeat (3) @(negedge clk);
    chk(up_ready_o && !dn_valid_o && !dn_lock_o && !up_rvalid_o, "R11", "reset outputs",
        {28'd0, up_ready_o, dn_valid_o, dn_lock_o, up_rvalid_o}, 32'h8);
    rst_ni = 1'b1;
    @(negedge clk);

    // R2 worked examples: set bit 2 of 0x20000300, clear bit 8 of 0x40010C0C
    run_op(32'h2200_6008, 1'b1, 32'h0000_0001, rd);
    chk(txn_addr[1] == 32'h2000_0300, "R2", "example one word", txn_addr[1], 32'h2000_0300);
    run_op(32'h2000_0300, 1'b0, 32'h0, rd);
    exp = seed_val(32'h2000_0300) | 32'h4;
    chk(rd == exp, "R2", "example one result", rd, exp);
    run_op(32'h4221_81A0, 1'b1, 32'hFFFF_FFFE, rd);
    run_op(32'h4001_0C0C, 1'b0, 32'h0, rd);
    exp = seed_val(32'h4001_0C0C) & ~32'h100;
    chk(rd == exp, "R2", "example two result", rd, exp);
    run_op(32'h4221_81A0, 1'b0, 32'h0, rd);
    chk(rd == 32'h0, "R4", "example two alias read", rd, 0);

    // R1 window edges
    run_op(32'h21FF_FFFC, 1'b0, 32'h0, rd);
    chk(txn_addr[0] == 32'h21FF_FFFC, "R1", "below window", txn_addr[0], 32'h21FF_FFFC);
    run_op(32'h23FF_FFFC, 1'b1, 32'h1, rd);
    chk(txn_addr[1] == 32'h200F_FFFC, "R1", "top of window", txn_addr[1], 32'h200F_FFFC);
    run_op(32'h2400_0000, 1'b1, 32'hDEAD_BEEF, rd);
    chk(txn_addr[0] == 32'h2400_0000, "R1", "above window", txn_addr[0], 32'h2400_0000);
    run_op(32'h41FF_FFFC, 1'b0, 32'h0, rd);
    chk(txn_n == 1, "R1", "below second window", 32'(txn_n), 1);
    run_op(32'h4200_0000, 1'b0, 32'h0, rd);
    chk(txn_addr[0] == 32'h4000_0000, "R1", "second window base", txn_addr[0], 32'h4000_0000);
    run_op(32'h4400_0000, 1'b0, 32'h0, rd);
    chk(txn_addr[0] == 32'h4400_0000, "R1", "above second window", txn_addr[0], 32'h4400_0000);

    // random mix over a small pool of words
    for (int i = 0; i < 400; i++) begin
      logic [31:0] base, a;
      int bitn, kind;
      base = ($urandom % 2) ? 32'h4000_0000 : 32'h2000_0000;
      w    = base + 32'h300 + 32'(($urandom % 6) * 4);
      bitn = int'($urandom % 32);
      kind = int'($urandom % 5);
      if (kind < 3) a = alias_of(w, bitn);
      else if (kind == 3) a = w;
      else a = 32'h6000_0000 + 32'(($urandom % 6) * 4);
      run_op(a, 1'($urandom % 2), $urandom, rd);
    end
    finish_run();
  end
endmodule